// File: doc/BRIEF.md
# Multiplexed Three-Digit Seven-Segment Display Driver

This block lights three seven-segment LED digits from three 4-bit BCD values while using a single BCD-to-segment converter. A refresh timer picks one digit at a time and moves through the digits in a fixed round. One select word steers both a 4-bit-wide three-way multiplexer and a digit-enable decoder. The multiplexer feeds the shared converter with the active digit's BCD value. The decoder turns on the matching digit. At a refresh rate of about 1 kHz per digit, persistence of vision makes all three digits appear lit together.

The segment lines are shared by all digits. Each digit has its own enable line. The segment and enable outputs come from registers that load on the same clock edge, so a newly enabled digit never shows the previous digit's pattern. A parameter sets the output levels for common-anode or common-cathode displays. BCD codes above nine blank the digit. The select word only takes the values 0, 1 and 2. The decoder turns every enable off for the spare code 3.

Top module: `seg_scan_driver`

## Requirements
- R1: While `rst` is high (synchronous, active high), every digit enable is at its inactive level and every segment is dark. After `rst` falls, digit 0 is the first digit shown.
- R2: Each digit stays enabled for exactly `REFRESH_DIV` clock cycles. The digits follow the order 0, 1, 2, 0, ... without end. Counting from the first clock edge after reset release as edge 1, edge n shows digit ((n-1)/`REFRESH_DIV`) mod 3.
- R3: From the first clock edge after reset release onward, exactly one digit enable is at its active level.
- R4: The segment pattern always belongs to the digit that is currently enabled. Segments and enables update on the same clock edge, one cycle after the BCD inputs are sampled.
- R5: Segments are numbered bit 0 = a through bit 6 = g. As active-high patterns {g..a}, BCD 0..9 map to 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R6: A BCD value from 10 to 15 blanks every segment of that digit. The other digits are not affected.
- R7: With `COMMON_ANODE`=0, a lit segment is driven 1 and an enabled digit is driven 0. With `COMMON_ANODE`=1, a lit segment is driven 0 and an enabled digit is driven 1.
- R8: Digit k takes its BCD value from `bcd_digits[4k+3:4k]` and is enabled by `dig_en[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bcd_digits | input | 12 | Three BCD values, digit 0 in the low nibble |
| seg | output | 7 | Shared segment lines, bit 0 = a ... bit 6 = g |
| dig_en | output | 3 | Per-digit enable lines, polarity set by COMMON_ANODE |

## Verification
On every cycle, the assertions check the following. The select word stays in range and only moves when the refresh count ends. It wraps from digit 2 to digit 0. At most one enable is active, and exactly one is active once reset is released. The lit enable matches the select value that was registered. An invalid BCD code produces dark segments. Only the bench scenarios can show the exact segment shapes for 0 to 9, the mapping of nibbles to enable lines, and the reset levels on the pins. They also cover the two polarities side by side and the exact dwell time of REFRESH_DIV cycles per digit, which the bench compares against its own cycle count.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  // Active-high segment shapes, bit 0 = a ... bit 6 = g; codes above nine are dark.
  function automatic logic [SEG_W-1:0] bcd_to_segments(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int DIV        = 16667,
  parameter int NUM_DIGITS = 3,
  parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SEL_W-1:0] sel
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_DIGITS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sel <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt <= '0;
      sel <= (sel == SEL_LAST) ? '0 : sel + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_sel_range: assert property (@(posedge clk) disable iff (rst)
    sel <= SEL_LAST);

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_LAST) |=> $stable(sel));

  a_r2_wrap_to_first: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_LAST && sel == SEL_LAST) |=> (sel == '0));

  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_LAST);

endmodule

// File: rtl/digit_mux.sv
module digit_mux #(
  parameter int NUM_DIGITS = 3,
  parameter int BCD_W      = 4,
  parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
  input  logic [NUM_DIGITS*BCD_W-1:0] bcd_all,
  input  logic [SEL_W-1:0]            sel,
  output logic [BCD_W-1:0]            bcd_cur
);
  always_comb begin
    bcd_cur = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (sel == SEL_W'(i)) bcd_cur = bcd_all[i*BCD_W +: BCD_W];
    end
  end
endmodule

// File: rtl/digit_decoder.sv
module digit_decoder #(
  parameter int NUM_DIGITS = 3,
  parameter int SEL_W      = $clog2(NUM_DIGITS)
) (
  input  logic [SEL_W-1:0]      sel,
  output logic [NUM_DIGITS-1:0] en_act
);
  // Spare select codes match no output, so every enable stays off.
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_line
    assign en_act[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver #(
  parameter int REFRESH_DIV  = 16667,
  parameter int NUM_DIGITS   = 3,
  parameter bit COMMON_ANODE = 1'b0
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [NUM_DIGITS*seg_scan_pkg::BCD_W-1:0]  bcd_digits,
  output logic [seg_scan_pkg::SEG_W-1:0]             seg,
  output logic [NUM_DIGITS-1:0]                      dig_en
);
  import seg_scan_pkg::*;

  localparam int SEL_W = $clog2(NUM_DIGITS);
  localparam logic [SEG_W-1:0]      SEG_DARK = COMMON_ANODE ? '1 : '0;
  localparam logic [NUM_DIGITS-1:0] EN_OFF   = COMMON_ANODE ? '0 : '1;

  logic [SEL_W-1:0]      sel;
  logic [BCD_W-1:0]      cur_bcd;
  logic [NUM_DIGITS-1:0] dec_en;
  logic [SEG_W-1:0]      seg_nxt;
  logic [NUM_DIGITS-1:0] en_nxt;
  logic [SEG_W-1:0]      seg_q;
  logic [NUM_DIGITS-1:0] en_q;

  refresh_timer #(.DIV(REFRESH_DIV), .NUM_DIGITS(NUM_DIGITS), .SEL_W(SEL_W)) u_timer (
    .clk (clk),
    .rst (rst),
    .sel (sel)
  );

  digit_mux #(.NUM_DIGITS(NUM_DIGITS), .BCD_W(BCD_W), .SEL_W(SEL_W)) u_mux (
    .bcd_all (bcd_digits),
    .sel     (sel),
    .bcd_cur (cur_bcd)
  );

  digit_decoder #(.NUM_DIGITS(NUM_DIGITS), .SEL_W(SEL_W)) u_dec (
    .sel    (sel),
    .en_act (dec_en)
  );

  // Polarity is applied ahead of the flops so the pins come straight from registers.
  if (COMMON_ANODE) begin : g_anode
    assign seg_nxt = ~bcd_to_segments(cur_bcd);
    assign en_nxt  = dec_en;
  end else begin : g_cathode
    assign seg_nxt = bcd_to_segments(cur_bcd);
    assign en_nxt  = ~dec_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= SEG_DARK;
      en_q  <= EN_OFF;
    end else begin
      seg_q <= seg_nxt;
      en_q  <= en_nxt;
    end
  end

  assign seg    = seg_q;
  assign dig_en = en_q;

  // Active-high views of the pins for the checks below.
  logic [SEG_W-1:0]      seg_lit;
  logic [NUM_DIGITS-1:0] en_lit;
  assign seg_lit = seg_q ^ SEG_DARK;
  assign en_lit  = en_q ^ EN_OFF;

  a_r3_at_most_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en_lit));

  a_r3_one_after_reset: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $onehot(en_lit));

  a_r4_enable_follows_select: assert property (@(posedge clk) disable iff (rst)
    (en_lit != '0) |-> en_lit[$past(sel)]);

  a_r6_invalid_blank: assert property (@(posedge clk) disable iff (rst)
    (cur_bcd > BCD_W'(9)) |=> (seg_lit == '0));

endmodule

// File: tb/tb_seg_scan_driver.sv
module tb_seg_scan_driver;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bcd_digits = '0;
  logic [6:0]  seg_cc, seg_ca;
  logic [2:0]  en_cc, en_ca;

  int errors = 0;
  int checks = 0;
  int n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_scan_driver #(.REFRESH_DIV(DIV), .NUM_DIGITS(3), .COMMON_ANODE(1'b0)) dut (
    .clk(clk), .rst(rst), .bcd_digits(bcd_digits), .seg(seg_cc), .dig_en(en_cc));

  seg_scan_driver #(.REFRESH_DIV(DIV), .NUM_DIGITS(3), .COMMON_ANODE(1'b1)) dut_ca (
    .clk(clk), .rst(rst), .bcd_digits(bcd_digits), .seg(seg_ca), .dig_en(en_ca));

  function automatic logic [6:0] shape(input logic [3:0] v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (v < 10) ? t[v] : 7'h00;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, n);
    end
  endtask

  task automatic step();
    int d;
    logic [3:0] v;
    logic [6:0] s;
    @(posedge clk);
    n++;
    @(negedge clk);
    d = ((n - 1) / DIV) % 3;
    v = bcd_digits[d*4 +: 4];
    s = shape(v);
    check("R2 R3 R8 enable", {4'b0, en_cc}, {4'b0, ~(3'b001 << d)});
    check(v > 9 ? "R6 blank" : "R4 R5 segments", seg_cc, s);
    check("R7 anode enable", {4'b0, en_ca}, {4'b0, 3'b001 << d});
    check("R7 anode segments", seg_ca, ~s);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 seg dark", seg_cc, 7'h00);
    check("R1 en off", {4'b0, en_cc}, 7'h07);
    check("R1 anode seg dark", seg_ca, 7'h7F);
    check("R1 anode en off", {4'b0, en_ca}, 7'h00);
    rst = 1'b0;
    n = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // Directed sweep: every code on all three digits for a full round.
    for (int v = 0; v < 16; v++) begin
      bcd_digits = {v[3:0], v[3:0], v[3:0]};
      repeat (3 * DIV) step();
    end
    // Mixed digits, including one invalid digit among valid ones (R6).
    bcd_digits = {4'd7, 4'd12, 4'd3};
    repeat (3 * DIV) step();
    // Reset in mid-round, then digit 0 must come first (R1).
    repeat (DIV + 1) step();
    do_reset();
    bcd_digits = {4'd2, 4'd1, 4'd0};
    repeat (6 * DIV) step();
    // Random stimulus, changing values on random cycles.
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 2) == 0) bcd_digits = 12'($urandom);
      step();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule